// File: doc/BRIEF.md
# Dual-Flow Operand Stack and Shared Locals Register Bank

This block is the register file of a two-issue stack machine. Each of the two execution flows owns a private operand stack, and both flows share one local-variable pool. All of this storage is held in flip-flops, not in a memory. Each stack has its own pointer. Each flow can see its two topmost entries on every cycle, so a two-operand instruction gets both of its inputs at once.

In a cycle, a flow may pop up to three entries and write one result back. The write-back goes either onto that flow's own stack or into the shared local pool at an index the flow supplies. Each flow also has its own read port into the local pool. Data that one flow stores in a local is visible to the other flow on the next cycle, with no transfer logic between the flows. Because an issue packet can carry a single instruction, a flow may be idle in any cycle. An idle flow drives no pops and no write-back. Flow 0 is the primary flow.

Top module: `dfsb_stack_bank`

## Requirements
- R1: After reset, both stack depths are 0, both error flags are 0, all top outputs read 0 and every local reads 0.
- R2: A write-back to the stack (wbEn=1, wbToLocal=0) with no pop on a stack that is not full raises the depth by one on the next cycle. The written word appears on topData0, and the previous top moves to topData1.
- R3: A pop count of n (1 to 3) with no push, on a stack holding at least n entries, lowers the depth by n on the next cycle. The top outputs then show the entries below those removed.
- R4: A pop and a stack write-back in the same cycle on the same flow first remove n entries and then push the new word. With n=1 the depth is unchanged and the top entry is replaced.
- R5: A pop count greater than the current depth is an underflow. The depth and stack contents stay unchanged, and that flow's error flag becomes 1.
- R6: A stack write-back that would leave more than 8 entries after the same cycle's pops is an overflow. The depth and contents stay unchanged, the error flag becomes 1, and the depth never exceeds 8.
- R7: An error flag, once set, stays 1 until reset, whatever the later operations are.
- R8: Operations on one flow never change the depth, contents, top outputs or error flag of the other flow.
- R9: A write-back to a local (wbEn=1, wbToLocal=1) stores wbData at index wbLocalIdx (0 to 15). From the next cycle on, either flow's local read port returns it. The stack of the writing flow is left unchanged.
- R10: When both flows write the same local index in one cycle, the value from flow 0 is stored.
- R11: topData0 reads 0 when the depth is 0, and topData1 reads 0 when the depth is below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| popCnt | input | 2x2 | Per-flow number of entries to pop this cycle (0 to 3) |
| wbEn | input | 2 | Per-flow write-back enable |
| wbToLocal | input | 2 | Per-flow write-back target: 1 = local pool, 0 = own stack |
| wbLocalIdx | input | 2x4 | Per-flow local index for a write-back to the pool |
| wbData | input | 2x32 | Per-flow write-back word |
| locRdIdx | input | 2x4 | Per-flow local read index |
| locRdData | output | 2x32 | Per-flow local read word (registered contents) |
| topData0 | output | 2x32 | Per-flow top-of-stack entry |
| topData1 | output | 2x32 | Per-flow entry below the top |
| stackDepth | output | 2x4 | Per-flow number of stacked entries (0 to 8) |
| errFlag | output | 2 | Per-flow sticky underflow/overflow flag |

## Verification
The bound checker checks on every cycle that the depth stays within bounds and that the error flags are sticky. It also checks that an underflow freezes the pointer while setting the flag, that a plain push grows the stack with the pushed word on top, and that a pop-plus-push replaces the top in place. Only the bench scenarios can show the rest. This covers the full contents of deep stacks after long mixed sequences, the isolation of the two flows, data crossing between the flows through the local pool, and the primary flow winning a same-index local write.

// File: rtl/dfsb_pkg.sv
package dfsb_pkg;
  localparam int NUM_FLOWS   = 2;
  localparam int DATA_W      = 32;
  localparam int STACK_DEPTH = 8;
  localparam int LOCAL_DEPTH = 16;
  localparam int POP_W       = 2;
  localparam int SA_W        = $clog2(STACK_DEPTH);
  localparam int PTR_W       = $clog2(STACK_DEPTH + 1);
  localparam int LA_W        = $clog2(LOCAL_DEPTH);

  // Strobes from one flow's control to the datapath
  typedef struct packed {
    logic            stackWe;
    logic [SA_W-1:0] stackAddr;
  } flowStrobe_t;
endpackage

// File: rtl/dfsb_flow_ctrl.sv
module dfsb_flow_ctrl
  import dfsb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [POP_W-1:0] popCnt,
  input  logic             pushReq,
  output flowStrobe_t      strobe,
  output logic [PTR_W-1:0] depth,
  output logic             err
);
  localparam int EXT_W = PTR_W + 1;

  logic [EXT_W-1:0] depthExt;
  logic [EXT_W-1:0] popExt;
  logic [EXT_W-1:0] baseExt;
  logic [EXT_W-1:0] nextExt;
  logic             underflow;
  logic             overflow;
  logic             bad;

  always_comb begin
    depthExt  = EXT_W'(depth);
    popExt    = EXT_W'(popCnt);
    underflow = popExt > depthExt;
    baseExt   = depthExt - popExt;
    nextExt   = baseExt + EXT_W'(pushReq);
    overflow  = !underflow && pushReq && (nextExt > EXT_W'(STACK_DEPTH));
    bad       = underflow || overflow;
    strobe.stackWe   = pushReq && !bad;
    strobe.stackAddr = baseExt[SA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth <= '0;
      err   <= 1'b0;
    end else begin
      if (!bad) depth <= nextExt[PTR_W-1:0];
      if (bad)  err   <= 1'b1;
    end
  end
endmodule

// File: rtl/dfsb_datapath.sv
module dfsb_datapath
  import dfsb_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  flowStrobe_t [NUM_FLOWS-1:0]        strobe,
  input  logic [NUM_FLOWS-1:0][PTR_W-1:0]    depth,
  input  logic [NUM_FLOWS-1:0][DATA_W-1:0]   wbData,
  input  logic [NUM_FLOWS-1:0]               locWe,
  input  logic [NUM_FLOWS-1:0][LA_W-1:0]     locWrIdx,
  input  logic [NUM_FLOWS-1:0][LA_W-1:0]     locRdIdx,
  output logic [NUM_FLOWS-1:0][DATA_W-1:0]   locRdData,
  output logic [NUM_FLOWS-1:0][DATA_W-1:0]   topData0,
  output logic [NUM_FLOWS-1:0][DATA_W-1:0]   topData1
);
  logic [DATA_W-1:0] locals [LOCAL_DEPTH];

  genvar f;
  generate
    for (f = 0; f < NUM_FLOWS; f++) begin : g_flow
      logic [DATA_W-1:0] stk [STACK_DEPTH];
      logic [SA_W-1:0]   idx0;
      logic [SA_W-1:0]   idx1;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= '0;
        end else if (strobe[f].stackWe) begin
          stk[strobe[f].stackAddr] <= wbData[f];
        end
      end

      always_comb begin
        idx0 = SA_W'(depth[f] - PTR_W'(1));
        idx1 = SA_W'(depth[f] - PTR_W'(2));
        topData0[f]  = (depth[f] >= PTR_W'(1)) ? stk[idx0] : '0;
        topData1[f]  = (depth[f] >= PTR_W'(2)) ? stk[idx1] : '0;
        locRdData[f] = locals[locRdIdx[f]];
      end
    end
  endgenerate

  // Higher flow index written first so flow 0 takes a same-index collision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LOCAL_DEPTH; i++) locals[i] <= '0;
    end else begin
      for (int k = NUM_FLOWS - 1; k >= 0; k--) begin
        if (locWe[k]) locals[locWrIdx[k]] <= wbData[k];
      end
    end
  end
endmodule

// File: rtl/dfsb_stack_bank.sv
module dfsb_stack_bank
  import dfsb_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_FLOWS-1:0][POP_W-1:0]    popCnt,
  input  logic [NUM_FLOWS-1:0]               wbEn,
  input  logic [NUM_FLOWS-1:0]               wbToLocal,
  input  logic [NUM_FLOWS-1:0][LA_W-1:0]     wbLocalIdx,
  input  logic [NUM_FLOWS-1:0][DATA_W-1:0]   wbData,
  input  logic [NUM_FLOWS-1:0][LA_W-1:0]     locRdIdx,
  output logic [NUM_FLOWS-1:0][DATA_W-1:0]   locRdData,
  output logic [NUM_FLOWS-1:0][DATA_W-1:0]   topData0,
  output logic [NUM_FLOWS-1:0][DATA_W-1:0]   topData1,
  output logic [NUM_FLOWS-1:0][PTR_W-1:0]    stackDepth,
  output logic [NUM_FLOWS-1:0]               errFlag
);
  flowStrobe_t [NUM_FLOWS-1:0] strobe;
  logic [NUM_FLOWS-1:0]        pushReq;
  logic [NUM_FLOWS-1:0]        locWe;

  assign pushReq = wbEn & ~wbToLocal;
  assign locWe   = wbEn & wbToLocal;

  genvar f;
  generate
    for (f = 0; f < NUM_FLOWS; f++) begin : g_ctrl
      dfsb_flow_ctrl u_ctrl (
        .clk     (clk),
        .rstN    (rstN),
        .popCnt  (popCnt[f]),
        .pushReq (pushReq[f]),
        .strobe  (strobe[f]),
        .depth   (stackDepth[f]),
        .err     (errFlag[f])
      );
    end
  endgenerate

  dfsb_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .depth     (stackDepth),
    .wbData    (wbData),
    .locWe     (locWe),
    .locWrIdx  (wbLocalIdx),
    .locRdIdx  (locRdIdx),
    .locRdData (locRdData),
    .topData0  (topData0),
    .topData1  (topData1)
  );
endmodule

// File: rtl/dfsb_checker.sv
module dfsb_checker
  import dfsb_pkg::*;
(
  input logic                               clk,
  input logic                               rstN,
  input logic [NUM_FLOWS-1:0][POP_W-1:0]    popCnt,
  input logic [NUM_FLOWS-1:0]               wbEn,
  input logic [NUM_FLOWS-1:0]               wbToLocal,
  input logic [NUM_FLOWS-1:0][DATA_W-1:0]   wbData,
  input logic [NUM_FLOWS-1:0][DATA_W-1:0]   topData0,
  input logic [NUM_FLOWS-1:0][PTR_W-1:0]    stackDepth,
  input logic [NUM_FLOWS-1:0]               errFlag
);
  genvar f;
  generate
    for (f = 0; f < NUM_FLOWS; f++) begin : g_chk
      assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
        stackDepth[f] <= PTR_W'(STACK_DEPTH));

      assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
        errFlag[f] |=> errFlag[f]);

      assert_underflow_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
        (PTR_W'(popCnt[f]) > stackDepth[f]) |=>
          (errFlag[f] && stackDepth[f] == $past(stackDepth[f])));

      assert_push_grow_R2: assert property (@(posedge clk) disable iff (!rstN)
        (wbEn[f] && !wbToLocal[f] && popCnt[f] == '0 &&
         stackDepth[f] < PTR_W'(STACK_DEPTH)) |=>
          (stackDepth[f] == $past(stackDepth[f]) + PTR_W'(1) &&
           topData0[f] == $past(wbData[f])));

      assert_replace_top_R4: assert property (@(posedge clk) disable iff (!rstN)
        (wbEn[f] && !wbToLocal[f] && popCnt[f] == POP_W'(1) &&
         stackDepth[f] != '0) |=>
          ($stable(stackDepth[f]) && topData0[f] == $past(wbData[f])));
    end
  endgenerate
endmodule

bind dfsb_stack_bank dfsb_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .popCnt     (popCnt),
  .wbEn       (wbEn),
  .wbToLocal  (wbToLocal),
  .wbData     (wbData),
  .topData0   (topData0),
  .stackDepth (stackDepth),
  .errFlag    (errFlag)
);

// File: tb/dfsb_stack_bank_tb.sv
module dfsb_stack_bank_tb;
  import dfsb_pkg::*;

  logic                               clk = 1'b0;
  logic                               rstN;
  logic [NUM_FLOWS-1:0][POP_W-1:0]    popCnt;
  logic [NUM_FLOWS-1:0]               wbEn;
  logic [NUM_FLOWS-1:0]               wbToLocal;
  logic [NUM_FLOWS-1:0][LA_W-1:0]     wbLocalIdx;
  logic [NUM_FLOWS-1:0][DATA_W-1:0]   wbData;
  logic [NUM_FLOWS-1:0][LA_W-1:0]     locRdIdx;
  logic [NUM_FLOWS-1:0][DATA_W-1:0]   locRdData;
  logic [NUM_FLOWS-1:0][DATA_W-1:0]   topData0;
  logic [NUM_FLOWS-1:0][DATA_W-1:0]   topData1;
  logic [NUM_FLOWS-1:0][PTR_W-1:0]    stackDepth;
  logic [NUM_FLOWS-1:0]               errFlag;

  always #5 clk = ~clk;

  dfsb_stack_bank u_dut (
    .clk(clk), .rstN(rstN), .popCnt(popCnt), .wbEn(wbEn), .wbToLocal(wbToLocal),
    .wbLocalIdx(wbLocalIdx), .wbData(wbData), .locRdIdx(locRdIdx),
    .locRdData(locRdData), .topData0(topData0), .topData1(topData1),
    .stackDepth(stackDepth), .errFlag(errFlag)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Bench model
  logic [DATA_W-1:0] mStk [NUM_FLOWS][STACK_DEPTH];
  int                mDepth [NUM_FLOWS];
  bit                mErr [NUM_FLOWS];
  logic [DATA_W-1:0] mLoc [LOCAL_DEPTH];
  string             flowTag [NUM_FLOWS];
  string             locTag;
  logic [31:0]       seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expTop(input int f, input int k);
    return (mDepth[f] > k) ? mStk[f][mDepth[f]-1-k] : 32'h0;
  endfunction

  task automatic compareAll();
    for (int f = 0; f < NUM_FLOWS; f++) begin
      string t0;
      string t1;
      t0 = (mDepth[f] < 1) ? "R11" : flowTag[f];
      t1 = (mDepth[f] < 2) ? "R11" : flowTag[f];
      chk(stackDepth[f] == PTR_W'(mDepth[f]), flowTag[f], "depth",
          32'(stackDepth[f]), 32'(mDepth[f]));
      chk(errFlag[f] == mErr[f], mErr[f] ? "R7" : flowTag[f], "err",
          32'(errFlag[f]), 32'(mErr[f]));
      chk(topData0[f] == expTop(f, 0), t0, "top0", topData0[f], expTop(f, 0));
      chk(topData1[f] == expTop(f, 1), t1, "top1", topData1[f], expTop(f, 1));
      chk(locRdData[f] == mLoc[locRdIdx[f]], locTag, "local",
          locRdData[f], mLoc[locRdIdx[f]]);
    end
  endtask

  // Drive one cycle, update the model, check after the edge
  task automatic step(input logic [1:0] p0, input logic [1:0] p1,
                      input bit e0, input bit e1, input bit l0, input bit l1,
                      input logic [3:0] i0, input logic [3:0] i1,
                      input logic [31:0] d0, input logic [31:0] d1,
                      input logic [3:0] r0, input logic [3:0] r1);
    int p [NUM_FLOWS];
    bit u [NUM_FLOWS];
    popCnt[0] = p0; popCnt[1] = p1;
    wbEn = {e1, e0}; wbToLocal = {l1, l0};
    wbLocalIdx[0] = i0; wbLocalIdx[1] = i1;
    wbData[0] = d0; wbData[1] = d1;
    locRdIdx[0] = r0; locRdIdx[1] = r1;
    p[0] = int'(p0); p[1] = int'(p1);
    u[0] = e0 && !l0; u[1] = e1 && !l1;
    for (int f = 0; f < NUM_FLOWS; f++) begin
      int d;
      d = mDepth[f];
      if (p[f] > d) begin
        mErr[f] = 1; flowTag[f] = "R5";
      end else if (d - p[f] + int'(u[f]) > STACK_DEPTH) begin
        mErr[f] = 1; flowTag[f] = "R6";
      end else begin
        if (u[f]) mStk[f][d - p[f]] = wbData[f];
        mDepth[f] = d - p[f] + int'(u[f]);
        flowTag[f] = (u[f] && p[f] > 0) ? "R4" : u[f] ? "R2" : (p[f] > 0) ? "R3" : "R8";
      end
    end
    if (e1 && l1) mLoc[i1] = d1;
    if (e0 && l0) mLoc[i0] = d0;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    popCnt = '0; wbEn = '0; wbToLocal = '0; wbLocalIdx = '0;
    wbData = '0; locRdIdx = '0;
    for (int f = 0; f < NUM_FLOWS; f++) begin
      mDepth[f] = 0; mErr[f] = 0;
      for (int i = 0; i < STACK_DEPTH; i++) mStk[f][i] = '0;
    end
    for (int i = 0; i < LOCAL_DEPTH; i++) mLoc[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, sweep every local through the read ports
    flowTag[0] = "R1"; flowTag[1] = "R1"; locTag = "R1";
    for (int i = 0; i < LOCAL_DEPTH; i++) begin
      locRdIdx[0] = LA_W'(i); locRdIdx[1] = LA_W'(LOCAL_DEPTH - 1 - i);
      #1 compareAll();
    end

    locTag = "R9";
    // R2/R8: fill flow 0 to full while flow 1 idles
    for (int k = 0; k < STACK_DEPTH; k++)
      step(2'd0, 2'd0, 1, 0, 0, 0, 4'd0, 4'd0, 32'hA000 + k, 32'h0, 4'd0, 4'd0);
    // R6: one more push overflows
    step(2'd0, 2'd0, 1, 0, 0, 0, 4'd0, 4'd0, 32'hDEAD, 32'h0, 4'd0, 4'd0);
    // R4: pop one + push at full replaces top
    step(2'd1, 2'd0, 1, 0, 0, 0, 4'd0, 4'd0, 32'hBEEF, 32'h0, 4'd0, 4'd0);
    // R3: pop three, then pops down to empty
    step(2'd3, 2'd0, 0, 0, 0, 0, 4'd0, 4'd0, 32'h0, 32'h0, 4'd0, 4'd0);
    step(2'd2, 2'd0, 0, 0, 0, 0, 4'd0, 4'd0, 32'h0, 32'h0, 4'd0, 4'd0);
    step(2'd3, 2'd0, 0, 0, 0, 0, 4'd0, 4'd0, 32'h0, 32'h0, 4'd0, 4'd0);
    // R5: underflow on flow 1 (empty)
    step(2'd0, 2'd1, 0, 0, 0, 0, 4'd0, 4'd0, 32'h0, 32'h0, 4'd0, 4'd0);
    // R9: flow 1 stores a local, flow 0 reads it next cycle
    step(2'd0, 2'd0, 0, 1, 0, 1, 4'd0, 4'd5, 32'h0, 32'h5555_0001, 4'd5, 4'd5);
    // R10: collision sweep over every local index
    locTag = "R10";
    for (int i = 0; i < LOCAL_DEPTH; i++)
      step(2'd0, 2'd0, 1, 1, 1, 1, LA_W'(i), LA_W'(i), 32'hF000 + i, 32'hE000 + i,
           LA_W'(i), LA_W'(i));
    // Mixed sweep: stack ops of all kinds on both flows, locals in between
    locTag = "R9";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [1:0]  pa;
      logic [1:0]  pb;
      a = rnd(); b = rnd();
      pa = (a[3:2] == 2'd0) ? a[5:4] : {1'b0, a[6]};
      pb = (b[3:2] == 2'd0) ? b[5:4] : {1'b0, b[6]};
      step(pa, pb, a[7] | a[8], b[7] | b[8], a[9] & a[10], b[9] & b[10],
           a[14:11], b[14:11], rnd(), rnd(), a[18:15], b[18:15]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule